// File: doc/BRIEF.md
# Peripheral Interrupt Flag and Mask Unit

This block collects three event sources from a caller-ID tone receiver into one peripheral interrupt request for a small microcontroller core. The sources are ring or line-polarity-reversal detection, carrier detection, and arrival of a demodulated data byte. Each source has a sticky event flag and an active-low enable mask. A global enable gates the combined condition. A request flag is raised on the rising edge of that condition, and the core then calls the fixed vector address presented on `vecAddr`.

Software sees two byte-wide registers through a simple write strobe and a combinational read port. The status register holds the flags and masks. The control register holds the global enable, the power-down bit and the request flag. Flags are set only by hardware and cleared only by software. An uncleared flag therefore keeps its source from producing a second request. Power-down stops flags from being captured, while both registers stay readable and writable.

Top module: `pirq_unit`

## Requirements
- R1: After reset the status register (address `STAT_ADDR`, default 2) reads 0x70 (all masks 1, all flags 0), the control register (address `CTRL_ADDR`, default 3) reads 0x00, and `irqReq` is 0.
- R2: A one-cycle pulse on an event input sets that source's flag at the next clock edge, even while the source is masked. In the status byte, ring is bit 0, carrier is bit 1 and data is bit 2.
- R3: Masks are active-low and occupy status bits 4 (ring), 5 (carrier) and 6 (data). A status write loads them from the written byte, and they read back unchanged.
- R4: With the global enable on, a set flag whose mask is 0 raises `irqReq` at the second clock edge after the flag appears. This includes a flag that was set while masked and is later unmasked. Each rise of the combined condition raises the request once.
- R5: While the global enable (control bit 0) is 0, `irqReq` never rises. Turning the enable on with an unmasked flag pending raises `irqReq` one edge later.
- R6: Flags are never cleared by hardware, including by `vecAck`. A status write of 0 to a flag bit clears it, and a write of 1 leaves it unchanged.
- R7: While a source's flag stays set, a new event from that source produces no new request.
- R8: While power-down (control bit 1) is 1, event pulses set no flag, and both registers remain readable and writable. Capture resumes once the bit is cleared.
- R9: An event pulse and a status write clearing the same flag in the same cycle leave the flag set.
- R10: The request flag (control bit 2) is cleared by `vecAck` or by a control write with bit 2 at 0. A control write with bit 2 at 1 does not set it. A rise of the condition in the same cycle as a clear sets it.
- R11: `vecAddr` always presents the vector address 0x010.
- R12: Reads from any address other than the two registers return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtRing | input | 1 | Ring / line-reversal event pulse |
| evtCarrier | input | 1 | Carrier detect event pulse |
| evtData | input | 1 | Received data event pulse |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for reads and writes |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data at `addr` |
| vecAck | input | 1 | Core acknowledges the vector call |
| irqReq | output | 1 | Peripheral interrupt request |
| vecAddr | output | VEC_W | Interrupt vector address |

## Verification
The bound checker watches several properties on every cycle. Flags rise after unpowered-down events and never fall without a status write. Nothing is captured in power-down. Masks follow status writes. The request only rises with the enable on and a pending unmasked flag, and it only falls after an acknowledge or a control write. Other behaviours need whole sequences and are shown only by the bench's scenarios: the exact two-edge latency, blocking of repeated events while a flag is held, the event-over-clear and set-over-acknowledge priorities, and resumption after power-down. The bench also checks readback of every register against a cycle model under random traffic.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int NUM_SRC  = 3;
  localparam int REG_W    = 8;
  localparam int FLAG_LSB = 0;
  localparam int MASK_LSB = 4;
  localparam int GIE_BIT  = 0;
  localparam int PD_BIT   = 1;
  localparam int PERF_BIT = 2;

  localparam int SRC_RING    = 0;
  localparam int SRC_CARRIER = 1;
  localparam int SRC_DATA    = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic               selStat;
    logic               selCtrl;
    logic               wrStat;
    logic               wrCtrl;
    logic [NUM_SRC-1:0] flagKeep;  // 1 = keep flag, 0 = clear
    logic [NUM_SRC-1:0] maskVal;
    logic               gieVal;
    logic               pdVal;
    logic               perfSet;
    logic               perfClr;
  } strobeT;
endpackage

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wrData,
  input  logic               vecAck,
  input  logic [NUM_SRC-1:0] pend,
  input  logic               gie,
  output strobeT             strobe
);
  logic condNow;
  logic condPrev;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData;
  assign condNow      = gie & (|pend);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) condPrev <= 1'b0;
    else       condPrev <= condNow;
  end

  always_comb begin
    strobe          = '0;
    strobe.selStat  = (addr == STAT_ADDR);
    strobe.selCtrl  = (addr == CTRL_ADDR);
    strobe.wrStat   = wrEn & strobe.selStat;
    strobe.wrCtrl   = wrEn & strobe.selCtrl;
    strobe.flagKeep = wrData[FLAG_LSB +: NUM_SRC];
    strobe.maskVal  = wrData[MASK_LSB +: NUM_SRC];
    strobe.gieVal   = wrData[GIE_BIT];
    strobe.pdVal    = wrData[PD_BIT];
    strobe.perfSet  = condNow & ~condPrev;
    strobe.perfClr  = vecAck | (strobe.wrCtrl & ~wrData[PERF_BIT]);
  end
endmodule

// File: rtl/pirq_datapath.sv
module pirq_datapath
  import pirq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtVec,
  input  strobeT             strobe,
  output logic [NUM_SRC-1:0] flagVec,
  output logic [NUM_SRC-1:0] maskVec,
  output logic [NUM_SRC-1:0] pend,
  output logic               gieOn,
  output logic               pdOn,
  output logic               perfOn,
  output logic [REG_W-1:0]   rdData
);
  logic [NUM_SRC-1:0] flagNext;
  logic [REG_W-1:0]   statWord;
  logic [REG_W-1:0]   ctrlWord;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    // an event wins over a same-cycle software clear
    assign flagNext[i] = (flagVec[i] & ~(strobe.wrStat & ~strobe.flagKeep[i]))
                       | (evtVec[i] & ~pdOn);
    assign pend[i]     = flagVec[i] & ~maskVec[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagVec <= '0;
      maskVec <= '1;
      gieOn   <= 1'b0;
      pdOn    <= 1'b0;
      perfOn  <= 1'b0;
    end else begin
      flagVec <= flagNext;
      if (strobe.wrStat) maskVec <= strobe.maskVal;
      if (strobe.wrCtrl) begin
        gieOn <= strobe.gieVal;
        pdOn  <= strobe.pdVal;
      end
      if (strobe.perfSet)      perfOn <= 1'b1;
      else if (strobe.perfClr) perfOn <= 1'b0;
    end
  end

  always_comb begin
    statWord                        = '0;
    statWord[FLAG_LSB +: NUM_SRC]   = flagVec;
    statWord[MASK_LSB +: NUM_SRC]   = maskVec;
    ctrlWord                        = '0;
    ctrlWord[GIE_BIT]               = gieOn;
    ctrlWord[PD_BIT]                = pdOn;
    ctrlWord[PERF_BIT]              = perfOn;
    if (strobe.selStat)      rdData = statWord;
    else if (strobe.selCtrl) rdData = ctrlWord;
    else                     rdData = '0;
  end
endmodule

// File: rtl/pirq_unit.sv
module pirq_unit
  import pirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h3,
  parameter int unsigned VEC_W = 12,
  parameter logic [VEC_W-1:0] VEC_ADDR = 'h010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtRing,
  input  logic              evtCarrier,
  input  logic              evtData,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic              vecAck,
  output logic              irqReq,
  output logic [VEC_W-1:0]  vecAddr
);
  strobeT             strobe;
  logic [NUM_SRC-1:0] evtVec;
  logic [NUM_SRC-1:0] flagVec;
  logic [NUM_SRC-1:0] maskVec;
  logic [NUM_SRC-1:0] pend;
  logic               gieOn;
  logic               pdOn;
  logic               perfOn;

  always_comb begin
    evtVec              = '0;
    evtVec[SRC_RING]    = evtRing;
    evtVec[SRC_CARRIER] = evtCarrier;
    evtVec[SRC_DATA]    = evtData;
  end

  pirq_ctrl #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .vecAck(vecAck), .pend(pend), .gie(gieOn), .strobe(strobe)
  );

  pirq_datapath u_dp (
    .clk(clk), .rstN(rstN), .evtVec(evtVec), .strobe(strobe),
    .flagVec(flagVec), .maskVec(maskVec), .pend(pend), .gieOn(gieOn),
    .pdOn(pdOn), .perfOn(perfOn), .rdData(rdData)
  );

  assign irqReq  = perfOn;
  assign vecAddr = VEC_ADDR;
endmodule

// File: rtl/pirq_checker.sv
module pirq_checker
  import pirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h3
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [REG_W-1:0]   wrData,
  input logic               vecAck,
  input logic [NUM_SRC-1:0] evtVec,
  input logic [NUM_SRC-1:0] flags,
  input logic [NUM_SRC-1:0] masks,
  input logic               gie,
  input logic               pd,
  input logic               perf
);
  a_r2_event_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    ((|evtVec) && !pd) |=> ((flags & $past(evtVec)) == $past(evtVec)));

  a_r6_no_hw_clear: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == STAT_ADDR) |=> ((flags & $past(flags)) == $past(flags)));

  a_r8_pd_no_capture: assert property (@(posedge clk) disable iff (!rstN)
    pd |=> ((flags & ~$past(flags)) == '0));

  a_r3_mask_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == STAT_ADDR) |=> (masks == $past(wrData[MASK_LSB +: NUM_SRC])));

  a_r5_no_req_without_gie: assert property (@(posedge clk) disable iff (!rstN)
    !gie |=> !$rose(perf));

  a_r4_req_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    $rose(perf) |-> $past(gie && (|(flags & ~masks))));

  a_r10_req_clear_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(perf) |-> $past(vecAck || (wrEn && addr == CTRL_ADDR)));
endmodule

bind pirq_unit pirq_checker #(
  .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .vecAck(vecAck), .evtVec(evtVec), .flags(flagVec), .masks(maskVec),
  .gie(gieOn), .pd(pdOn), .perf(perfOn)
);

// File: tb/test_pirq_unit.sv
module test_pirq_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] STAT = 4'h2;
  localparam logic [3:0] CTRL = 4'h3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtRing = 1'b0, evtCarrier = 1'b0, evtData = 1'b0;
  logic wrEn = 1'b0, vecAck = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic irqReq;
  logic [11:0] vecAddr;

  int total = 0;
  int bad = 0;

  // bench reference state
  logic [2:0] mFlag = '0, mMask = '1;
  logic mGie = 0, mPd = 0, mPerf = 0, mPrev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pirq_unit i_pirq_unit (
    .clk(clk), .rstN(rstN), .evtRing(evtRing), .evtCarrier(evtCarrier),
    .evtData(evtData), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .vecAck(vecAck), .irqReq(irqReq), .vecAddr(vecAddr)
  );

  function automatic logic [7:0] expRead(input logic [3:0] a);
    if (a == STAT) return {1'b0, mMask, 1'b0, mFlag};
    if (a == CTRL) return {5'b0, mPerf, mPd, mGie};
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] ev, input logic w, input logic [3:0] a,
                      input logic [7:0] d, input logic ak);
    logic cond;
    logic [2:0] clr;
    {evtData, evtCarrier, evtRing} = ev;
    wrEn = w; addr = a; wrData = d; vecAck = ak;
    @(posedge clk);
    cond = mGie && ((mFlag & ~mMask) != 0);
    if (cond && !mPrev) mPerf = 1;
    else if (ak || (w && a == CTRL && !d[2])) mPerf = 0;
    mPrev = cond;
    clr = (w && a == STAT) ? ~d[2:0] : 3'b000;
    mFlag = (mFlag & ~clr) | (mPd ? 3'b000 : ev);
    if (w && a == STAT) mMask = d[6:4];
    if (w && a == CTRL) begin mGie = d[0]; mPd = d[1]; end
    @(negedge clk);
    evtRing = 0; evtCarrier = 0; evtData = 0; wrEn = 0; vecAck = 0;
  endtask

  task automatic peek(input string tag, input logic [3:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  task automatic idle();
    step(3'b000, 0, addr, 8'h00, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    peek("R1 stat", STAT, 8'h70);
    peek("R1 ctrl", CTRL, 8'h00);
    check("R1 irq", irqReq, 0);
    check("R11 vector", vecAddr, 12'h010);
    peek("R12 unmapped", 4'h5, 8'h00);

    // R2 masked event still sets flag
    step(3'b010, 0, STAT, 0, 0);
    peek("R2 carrier flag", STAT, 8'h72);
    check("R2 masked no req", irqReq, 0);

    // R4 unmask carrier with gie
    step(3'b000, 1, CTRL, 8'h01, 0);
    step(3'b000, 1, STAT, 8'h52, 0);
    check("R4 not yet", irqReq, 0);
    peek("R3 mask readback", STAT, 8'h52);
    idle();
    check("R4 req raised", irqReq, 1);
    peek("R10 perf bit", CTRL, 8'h05);

    // R6 ack does not clear flags
    step(3'b000, 0, STAT, 0, 1);
    check("R10 ack clears", irqReq, 0);
    peek("R6 flag kept after ack", STAT, 8'h52);

    // R7 repeat event with flag held
    step(3'b010, 0, STAT, 0, 0);
    idle();
    check("R7 no second req", irqReq, 0);

    // R6 clear by writing 0, write 1 does not set
    step(3'b000, 1, STAT, 8'h51, 0);
    peek("R6 clear and no set", STAT, 8'h50);

    // R4 flag set while masked, later unmasked
    step(3'b100, 0, STAT, 0, 0);
    step(3'b001, 0, STAT, 0, 0);
    peek("R2 data and ring", STAT, 8'h55);
    check("R2 masked no req 2", irqReq, 0);
    step(3'b000, 1, STAT, 8'h45, 0);
    check("R4 latency edge1", irqReq, 0);
    idle();
    check("R4 unmask raises", irqReq, 1);
    step(3'b000, 1, CTRL, 8'h01, 0);
    check("R10 write0 clears", irqReq, 0);
    step(3'b000, 1, CTRL, 8'h05, 0);
    check("R10 write1 no set", irqReq, 0);

    // R5 global enable
    step(3'b000, 1, CTRL, 8'h00, 0);
    step(3'b000, 1, STAT, 8'h00, 0);
    step(3'b001, 0, STAT, 0, 0);
    idle();
    check("R5 gie off", irqReq, 0);
    step(3'b000, 1, CTRL, 8'h01, 0);
    check("R5 enable edge", irqReq, 0);
    idle();
    check("R5 enable raises", irqReq, 1);
    step(3'b000, 0, STAT, 0, 1);

    // R9 event beats clear
    step(3'b001, 1, STAT, 8'h00, 0);
    peek("R9 event wins", STAT, 8'h01);

    // R8 power-down
    step(3'b000, 1, CTRL, 8'h03, 0);
    step(3'b000, 1, STAT, 8'h00, 0);
    step(3'b101, 0, STAT, 0, 0);
    peek("R8 no capture", STAT, 8'h00);
    check("R8 no req", irqReq, 0);
    step(3'b000, 1, STAT, 8'h70, 0);
    peek("R8 stat writable", STAT, 8'h70);
    peek("R8 ctrl readable", CTRL, 8'h03);
    step(3'b000, 1, CTRL, 8'h01, 0);
    step(3'b000, 1, STAT, 8'h00, 0);
    step(3'b100, 0, STAT, 0, 0);
    peek("R8 resume", STAT, 8'h04);
    // R10 rise of condition beats ack in the same cycle
    step(3'b000, 0, STAT, 0, 1);
    check("R10 set wins", irqReq, 1);
    step(3'b000, 0, STAT, 0, 1);
    check("R10 ack after", irqReq, 0);

    // random traffic against the reference state (R2 R3 R4 R6 R10)
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] ev;
      logic w, ak;
      logic [3:0] a;
      logic [7:0] d;
      ev = 3'b000;
      for (int k = 0; k < 3; k++) ev[k] = ($urandom % 8) == 0;
      w  = ($urandom % 5) == 0;
      case ($urandom % 4)
        0, 1: a = STAT;
        2: a = CTRL;
        default: a = 4'($urandom);
      endcase
      d = 8'($urandom);
      if (($urandom % 4) != 0) d[1] = 1'b0;
      ak = ($urandom % 10) == 0;
      step(ev, w, a, d, ak);
      check("R4 random irq", irqReq, mPerf);
      check("R6 random read", rdData, expRead(a));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule